// File: doc/BRIEF.md
# Secure Block Gate Configuration Register File

This block holds the configuration of a memory gate that decides, one fixed-size memory block at a time, whether secure or non-secure masters may reach the memory behind it. The map is a bit table of 32-bit words. A set bit opens its block to non-secure traffic and a clear bit keeps it secure. Software does not address the table directly. It sets a word pointer and then reads or writes a single window register, and the pointer can step forward by itself after each full-word window access.

A separate filter block uses the two side ports. The lookup port returns the table bit for any block number in the same cycle. The fault port loads the first blocked access into two read-only information registers and raises the interrupt status. The block also holds a control register with three live bits: error-response select, pointer auto-step and a sticky lockdown. It also has interrupt status, enable, set and clear registers. Configuration space is closed to accesses that lack the secure attribute. A read answers one cycle after it is accepted.

Top module: `secgate_regfile`

## Requirements
- R1: A read returns its data on `rspRdata` with `rspValid` high exactly one cycle after the request, and writes produce no response. The write-only offsets 0x24 and 0x34, the unused offset 0x08 and any offset that does not decode read as zero. No access ever reports an error.
- R2: After reset the following values hold: control word 0x100 (auto-step on), pointer 0, interrupt status 0, interrupt enable 1, both fault registers 0, every table word 0, and `irq` low.
- R3: The control word at 0x00 keeps bit 4 (error-response select, driven on `secErrResp`), bit 8 (auto-step) and bit 31 (lockdown). Every other bit reads 0 and ignores writes.
- R4: Offset 0x10 reads NUM_WORDS-1 and offset 0x14 reads BLOCK_LOG2-5. A write to the pointer at 0x18 stores the written word modulo NUM_WORDS, and the pointer never leaves the range 0..NUM_WORDS-1.
- R5: The window at 0x1C reads and writes the table word that the pointer selects. When auto-step is set and all four byte enables are high, the pointer then moves up by one and wraps from NUM_WORDS-1 to 0. An access with fewer byte enables leaves the pointer alone.
- R6: While lockdown is set, writes to the control word, the window and the interrupt enable (0x28) have no effect, and a discarded window write does not step the pointer. Window reads and pointer writes still work. Only reset clears lockdown.
- R7: An access with `reqSecure` low to any offset below 0xFD0 reads zero and changes no state.
- R8: For a write with some byte enables low, the control word, pointer and window keep their old bytes in the disabled lanes. For every other register the disabled lanes count as zero.
- R9: Writing a 1 in bit 0 of 0x34 sets the interrupt status and writing a 1 in bit 0 of 0x24 clears it. Bit 0 of 0x28 is the enable, status reads at 0x20 bit 0, and `irq` equals status AND enable.
- R10: A `faultValid` pulse while the status is clear loads `faultAddr` into 0x2C and `faultInfo` into 0x30 and sets the status. While the status is set, further faults leave both registers unchanged.
- R11: `lkNonSec` shows table bit `lkBlock[4:0]` of word `lkBlock[LK_W-1:5]` in the same cycle, and reads 0 when that word index is NUM_WORDS or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Register access request this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 12 | Byte address in the register window |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte lane enables |
| reqSecure | input | 1 | Access carries the secure attribute |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 32 | Read data |
| faultValid | input | 1 | Filter reports a blocked access |
| faultAddr | input | 32 | Address of the blocked access |
| faultInfo | input | 32 | Master and attribute details of the blocked access |
| lkBlock | input | PTR_W+5 | Block number to look up |
| lkNonSec | output | 1 | Table bit for `lkBlock` |
| secErrResp | output | 1 | Error-response select for blocked accesses |
| irq | output | 1 | Interrupt request |

## Verification
The pointer is the hidden state. If it is wrong, a later window access goes to the wrong word, so the bench reads the pointer back after every auto-step, wrap and narrow access, one cycle after the access. A lost or wrongly gated write would otherwise show up only when the word is next read. The bench therefore reads each table word back through the window and also probes it on the lookup port in the same cycle. An interrupt or lockdown fault shows at `irq` or in a control readback on the cycle after the write that should have caused or been blocked by it.

// File: rtl/secgate_pkg.sv
package secgate_pkg;

  localparam int unsigned OFS_W = 10;

  // word offsets (byte address / 4)
  localparam logic [OFS_W-1:0] OFS_CTL   = 10'h000;
  localparam logic [OFS_W-1:0] OFS_TOP   = 10'h004;
  localparam logic [OFS_W-1:0] OFS_SHIFT = 10'h005;
  localparam logic [OFS_W-1:0] OFS_PTR   = 10'h006;
  localparam logic [OFS_W-1:0] OFS_WIN   = 10'h007;
  localparam logic [OFS_W-1:0] OFS_STAT  = 10'h008;
  localparam logic [OFS_W-1:0] OFS_CLR   = 10'h009;
  localparam logic [OFS_W-1:0] OFS_EN    = 10'h00A;
  localparam logic [OFS_W-1:0] OFS_FADDR = 10'h00B;
  localparam logic [OFS_W-1:0] OFS_FINFO = 10'h00C;
  localparam logic [OFS_W-1:0] OFS_SET   = 10'h00D;
  localparam logic [OFS_W-1:0] OFS_OPEN  = 10'h3F4;  // first offset open to non-secure

  localparam int unsigned CTL_RESP_BIT = 4;
  localparam int unsigned CTL_STEP_BIT = 8;
  localparam int unsigned CTL_LOCK_BIT = 31;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTL, SEL_TOP, SEL_SHIFT, SEL_PTR, SEL_WIN,
    SEL_STAT, SEL_CLR, SEL_EN, SEL_FADDR, SEL_FINFO, SEL_SET
  } regSel_e;

  typedef struct packed {
    logic    wrCtl;
    logic    wrPtr;
    logic    wrWin;
    logic    wrEn;
    logic    wrClr;
    logic    wrSet;
    logic    ptrStep;
    logic    rdStb;
    regSel_e rdSel;
  } cfgStrobe_t;

  function automatic logic [31:0] mergeLanes(input logic [31:0] oldWord,
                                             input logic [31:0] newWord,
                                             input logic [3:0]  be);
    logic [31:0] res;
    for (int b = 0; b < 4; b++) begin
      res[b*8 +: 8] = be[b] ? newWord[b*8 +: 8] : oldWord[b*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/secgate_decode.sv
module secgate_decode
  import secgate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [11:0] reqAddr,
  input  logic [3:0]  reqBe,
  input  logic        reqSecure,
  input  logic        ctlLock,
  input  logic        ctlStep,
  output cfgStrobe_t  stb,
  output logic        rspValid
);

  logic [OFS_W-1:0] wordOfs;
  logic             unusedLaneBits;
  regSel_e          hitSel;
  logic             accessOk;
  logic             wrAcc;
  logic             rdAcc;
  logic             fullWord;

  assign wordOfs        = reqAddr[11:2];
  assign unusedLaneBits = ^reqAddr[1:0];
  assign accessOk       = reqSecure || (wordOfs >= OFS_OPEN);
  assign wrAcc          = reqValid && reqWrite && accessOk;
  assign rdAcc          = reqValid && !reqWrite && accessOk;
  assign fullWord       = (reqBe == 4'hF);

  always_comb begin
    case (wordOfs)
      OFS_CTL:   hitSel = SEL_CTL;
      OFS_TOP:   hitSel = SEL_TOP;
      OFS_SHIFT: hitSel = SEL_SHIFT;
      OFS_PTR:   hitSel = SEL_PTR;
      OFS_WIN:   hitSel = SEL_WIN;
      OFS_STAT:  hitSel = SEL_STAT;
      OFS_CLR:   hitSel = SEL_CLR;
      OFS_EN:    hitSel = SEL_EN;
      OFS_FADDR: hitSel = SEL_FADDR;
      OFS_FINFO: hitSel = SEL_FINFO;
      OFS_SET:   hitSel = SEL_SET;
      default:   hitSel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.wrCtl   = wrAcc && (hitSel == SEL_CTL) && !ctlLock;
    stb.wrPtr   = wrAcc && (hitSel == SEL_PTR);
    stb.wrWin   = wrAcc && (hitSel == SEL_WIN) && !ctlLock;
    stb.wrEn    = wrAcc && (hitSel == SEL_EN) && !ctlLock;
    stb.wrClr   = wrAcc && (hitSel == SEL_CLR);
    stb.wrSet   = wrAcc && (hitSel == SEL_SET);
    stb.ptrStep = ctlStep && fullWord && (hitSel == SEL_WIN) &&
                  (rdAcc || (wrAcc && !ctlLock));
    stb.rdStb   = reqValid && !reqWrite;
    stb.rdSel   = rdAcc ? hitSel : SEL_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid && !reqWrite;
  end

  AST_NS_NO_CFG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqSecure && (reqAddr[11:2] < OFS_OPEN)) |->
      !(stb.wrCtl || stb.wrPtr || stb.wrWin || stb.wrEn || stb.wrClr || stb.wrSet || stb.ptrStep)); // R7

  AST_NARROW_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.ptrStep |-> (reqBe == 4'hF)); // R5

  AST_LOCK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctlLock |-> !(stb.wrCtl || stb.wrWin || stb.wrEn)); // R6

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid); // R1

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> !rspValid); // R1

endmodule

// File: rtl/secgate_store.sv
module secgate_store
  import secgate_pkg::*;
#(
  parameter int NUM_WORDS  = 5,
  parameter int BLOCK_LOG2 = 12,
  parameter int PTR_W      = 3,
  parameter int LK_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       stb,
  input  logic [31:0]      reqWdata,
  input  logic [3:0]       reqBe,
  input  logic             faultValid,
  input  logic [31:0]      faultAddr,
  input  logic [31:0]      faultInfo,
  input  logic [LK_W-1:0]  lkBlock,
  output logic             lkNonSec,
  output logic [31:0]      rspRdata,
  output logic             ctlLock,
  output logic             ctlStep,
  output logic             secErrResp,
  output logic             irq
);

  localparam logic [31:0]      WORDS32  = 32'(NUM_WORDS);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_WORDS - 1);
  localparam logic [31:0]      TOP_VAL  = 32'(NUM_WORDS - 1);
  localparam logic [31:0]      SHIFT_VAL = 32'(BLOCK_LOG2 - 5);

  logic                      respQ, stepQ, lockQ;
  logic [PTR_W-1:0]          ptrQ;
  logic [PTR_W-1:0]          ptrLoad;
  logic [NUM_WORDS*32-1:0]   lutFlat;
  logic [31:0]               winWord;
  logic [31:0]               winNew;
  logic [31:0]               ptrMerged;
  logic [31:0]               ctlWord;
  logic                      intStatQ, intEnQ;
  logic [31:0]               faultAddrQ, faultInfoQ;
  logic [31:0]               rdMux;
  logic [31:0]               lkWord;
  logic                      lane0One;
  logic                      captureFault;

  assign lane0One     = reqBe[0] && reqWdata[0];
  assign captureFault = faultValid && !intStatQ;

  // table word at the pointer and lookup word
  always_comb begin
    winWord = '0;
    lkWord  = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (ptrQ == PTR_W'(i)) winWord = lutFlat[i*32 +: 32];
      if (lkBlock[LK_W-1:5] == PTR_W'(i)) lkWord = lutFlat[i*32 +: 32];
    end
  end

  assign lkNonSec  = lkWord[lkBlock[4:0]];
  assign winNew    = mergeLanes(winWord, reqWdata, reqBe);
  assign ptrMerged = mergeLanes({{(32-PTR_W){1'b0}}, ptrQ}, reqWdata, reqBe);
  assign ptrLoad   = PTR_W'(ptrMerged % WORDS32);

  // control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respQ <= 1'b0;
      stepQ <= 1'b1;
      lockQ <= 1'b0;
    end else if (stb.wrCtl) begin
      if (reqBe[0]) respQ <= reqWdata[CTL_RESP_BIT];
      if (reqBe[1]) stepQ <= reqWdata[CTL_STEP_BIT];
      if (reqBe[3]) lockQ <= reqWdata[CTL_LOCK_BIT];
    end
  end

  always_comb begin
    ctlWord               = '0;
    ctlWord[CTL_RESP_BIT] = respQ;
    ctlWord[CTL_STEP_BIT] = stepQ;
    ctlWord[CTL_LOCK_BIT] = lockQ;
  end

  // word pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (stb.wrPtr) begin
      ptrQ <= ptrLoad;
    end else if (stb.ptrStep) begin
      ptrQ <= (ptrQ == PTR_LAST) ? '0 : ptrQ + 1'b1;
    end
  end

  // table words
  for (genvar g = 0; g < NUM_WORDS; g++) begin : gen_word
    logic [31:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  wordQ <= '0;
      else if (stb.wrWin && ptrQ == PTR_W'(g))    wordQ <= winNew;
    end
    assign lutFlat[g*32 +: 32] = wordQ;
  end

  // interrupt and fault capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnQ <= 1'b1;
    end else if (stb.wrEn) begin
      intEnQ <= lane0One;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStatQ   <= 1'b0;
      faultAddrQ <= '0;
      faultInfoQ <= '0;
    end else if (captureFault) begin
      intStatQ   <= 1'b1;
      faultAddrQ <= faultAddr;
      faultInfoQ <= faultInfo;
    end else if (stb.wrSet && lane0One) begin
      intStatQ <= 1'b1;
    end else if (stb.wrClr && lane0One) begin
      intStatQ <= 1'b0;
    end
  end

  // read data
  always_comb begin
    case (stb.rdSel)
      SEL_CTL:   rdMux = ctlWord;
      SEL_TOP:   rdMux = TOP_VAL;
      SEL_SHIFT: rdMux = SHIFT_VAL;
      SEL_PTR:   rdMux = {{(32-PTR_W){1'b0}}, ptrQ};
      SEL_WIN:   rdMux = winWord;
      SEL_STAT:  rdMux = {31'b0, intStatQ};
      SEL_EN:    rdMux = {31'b0, intEnQ};
      SEL_FADDR: rdMux = faultAddrQ;
      SEL_FINFO: rdMux = faultInfoQ;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rspRdata <= '0;
    else if (stb.rdStb) rspRdata <= rdMux;
  end

  assign ctlLock    = lockQ;
  assign ctlStep    = stepQ;
  assign secErrResp = respQ;
  assign irq        = intStatQ && intEnQ;

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ptrQ <= PTR_LAST); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ); // R6

  AST_LOCK_FREEZES_EN: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(intEnQ)); // R6

  AST_INFO_HELD: assert property (@(posedge clk) disable iff (!rstN)
    intStatQ |=> ($stable(faultAddrQ) && $stable(faultInfoQ))); // R10

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrClr && lane0One && !faultValid) |=> !irq); // R9

endmodule

// File: rtl/secgate_regfile.sv
module secgate_regfile
  import secgate_pkg::*;
#(
  parameter  int NUM_WORDS  = 5,
  parameter  int BLOCK_LOG2 = 12,
  localparam int PTR_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int LK_W       = PTR_W + 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [11:0]      reqAddr,
  input  logic [31:0]      reqWdata,
  input  logic [3:0]       reqBe,
  input  logic             reqSecure,
  output logic             rspValid,
  output logic [31:0]      rspRdata,
  input  logic             faultValid,
  input  logic [31:0]      faultAddr,
  input  logic [31:0]      faultInfo,
  input  logic [LK_W-1:0]  lkBlock,
  output logic             lkNonSec,
  output logic             secErrResp,
  output logic             irq
);

  cfgStrobe_t stb;
  logic       ctlLock;
  logic       ctlStep;

  secgate_decode u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqBe     (reqBe),
    .reqSecure (reqSecure),
    .ctlLock   (ctlLock),
    .ctlStep   (ctlStep),
    .stb       (stb),
    .rspValid  (rspValid)
  );

  secgate_store #(
    .NUM_WORDS  (NUM_WORDS),
    .BLOCK_LOG2 (BLOCK_LOG2),
    .PTR_W      (PTR_W),
    .LK_W       (LK_W)
  ) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqWdata   (reqWdata),
    .reqBe      (reqBe),
    .faultValid (faultValid),
    .faultAddr  (faultAddr),
    .faultInfo  (faultInfo),
    .lkBlock    (lkBlock),
    .lkNonSec   (lkNonSec),
    .rspRdata   (rspRdata),
    .ctlLock    (ctlLock),
    .ctlStep    (ctlStep),
    .secErrResp (secErrResp),
    .irq        (irq)
  );

endmodule

// File: tb/secgate_regfile_bench.sv
`timescale 1ns/1ps
module secgate_regfile_bench;

  localparam int NW    = 5;
  localparam int BL    = 12;
  localparam int PTR_W = 3;
  localparam int LK_W  = PTR_W + 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqWrite = 1'b0;
  logic [11:0]     reqAddr = '0;
  logic [31:0]     reqWdata = '0;
  logic [3:0]      reqBe = '0;
  logic            reqSecure = 1'b0;
  logic            rspValid;
  logic [31:0]     rspRdata;
  logic            faultValid = 1'b0;
  logic [31:0]     faultAddr = '0;
  logic [31:0]     faultInfo = '0;
  logic [LK_W-1:0] lkBlock = '0;
  logic            lkNonSec;
  logic            secErrResp;
  logic            irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  secgate_regfile #(.NUM_WORDS(NW), .BLOCK_LOG2(BL)) u_secgate_regfile (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .reqSecure(reqSecure),
    .rspValid(rspValid), .rspRdata(rspRdata), .faultValid(faultValid),
    .faultAddr(faultAddr), .faultInfo(faultInfo), .lkBlock(lkBlock),
    .lkNonSec(lkNonSec), .secErrResp(secErrResp), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read response
  always @(negedge clk) begin : monitor
    logic [31:0] e;
    string t;
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R1 unexpected response actual=%h expected=none", rspRdata);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, rspRdata, e);
      end
    end
  end

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d,
                          input logic [3:0] be = 4'hF, input logic sec = 1'b1);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d; reqBe = be; reqSecure = sec;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [31:0] exp, input string tag,
                         input logic [3:0] be = 4'hF, input logic sec = 1'b1);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqBe = be; reqSecure = sec;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic pulseFault(input logic [31:0] a, input logic [31:0] inf);
    @(negedge clk);
    faultValid = 1'b1; faultAddr = a; faultInfo = inf;
    @(negedge clk);
    faultValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic lookup(input int blk, input logic exp, input string tag);
    @(negedge clk);
    lkBlock = LK_W'(blk);
    #1;
    check(tag, {31'b0, lkNonSec}, {31'b0, exp});
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R1 watchdog actual=running expected=done");
    finishRun();
  end

  initial begin : driver
    doReset();
    // R2 reset state
    check("R2 irq after reset", {31'b0, irq}, 32'h0);
    busRead(12'h000, 32'h0000_0100, "R2 ctl reset");
    busRead(12'h018, 32'h0, "R2 ptr reset");
    busRead(12'h020, 32'h0, "R2 status reset");
    busRead(12'h028, 32'h1, "R2 enable reset");
    busRead(12'h02C, 32'h0, "R2 fault addr reset");
    busRead(12'h030, 32'h0, "R2 fault info reset");
    busRead(12'h01C, 32'h0, "R2 table word reset", 4'h1);
    busRead(12'h018, 32'h0, "R5 narrow read keeps ptr");

    // R4 geometry
    busRead(12'h010, 32'(NW - 1), "R4 word top");
    busRead(12'h014, 32'(BL - 5), "R4 block shift");

    // R3 control bits
    busWrite(12'h000, 32'h7FFF_FFFF);
    busRead(12'h000, 32'h0000_0110, "R3 ctl keeps live bits");
    check("R3 secErrResp", {31'b0, secErrResp}, 32'h1);
    busWrite(12'h000, 32'h0000_0010);
    busRead(12'h000, 32'h0000_0010, "R3 ctl step off");
    busWrite(12'h000, 32'h0000_0100);

    // R4 pointer modulo
    busWrite(12'h018, 32'd7);
    busRead(12'h018, 32'd2, "R4 ptr 7 mod 5");
    busWrite(12'h018, 32'hFFFF_FFFF);
    busRead(12'h018, 32'd0, "R4 ptr max mod 5");
    busWrite(12'h018, 32'd13);
    busRead(12'h018, 32'd3, "R4 ptr 13 mod 5");

    // R5 window with auto-step and wrap
    busWrite(12'h01C, 32'hA5A5_0001);
    busWrite(12'h01C, 32'h8000_0000);
    busRead(12'h018, 32'd0, "R5 ptr wrapped");
    busWrite(12'h01C, 32'h0000_00F0);
    busRead(12'h018, 32'd1, "R5 ptr stepped");
    busWrite(12'h018, 32'd3);
    busRead(12'h01C, 32'hA5A5_0001, "R5 word3 readback");
    busRead(12'h01C, 32'h8000_0000, "R5 word4 readback");
    busRead(12'h018, 32'd0, "R5 read step wrap");

    // R11 lookup port
    lookup(96, 1'b1, "R11 block 96");
    lookup(97, 1'b0, "R11 block 97");
    lookup(159, 1'b1, "R11 block 159");
    lookup(4, 1'b1, "R11 block 4");
    lookup(3, 1'b0, "R11 block 3");
    lookup(200, 1'b0, "R11 out of range");

    // R8 narrow merge
    busWrite(12'h018, 32'd1);
    busWrite(12'h01C, 32'h0055_0000, 4'b0100);
    busWrite(12'h01C, 32'h0000_0033, 4'b0001);
    busRead(12'h018, 32'd1, "R5 narrow write keeps ptr");
    busRead(12'h01C, 32'h0055_0033, "R8 window merge");
    busRead(12'h018, 32'd2, "R5 full read steps");
    busWrite(12'h000, 32'h0000_0010, 4'b0001);
    busRead(12'h000, 32'h0000_0110, "R8 ctl byte merge");
    busWrite(12'h000, 32'h0000_0000, 4'b0010);
    busRead(12'h000, 32'h0000_0010, "R8 ctl byte1 merge");
    busWrite(12'h000, 32'h0000_0100);
    busWrite(12'h028, 32'h0000_0101, 4'b0010);
    busRead(12'h028, 32'h0, "R8 enable zero fill");
    busWrite(12'h028, 32'h1);
    busRead(12'h028, 32'h1, "R9 enable set");

    // R9 interrupt
    busWrite(12'h034, 32'h1);
    check("R9 irq after set", {31'b0, irq}, 32'h1);
    busWrite(12'h028, 32'h0);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    busRead(12'h020, 32'h1, "R9 status held while masked");
    busWrite(12'h028, 32'h1);
    check("R9 irq unmasked", {31'b0, irq}, 32'h1);
    busWrite(12'h024, 32'h2);
    check("R9 clear bit0 zero", {31'b0, irq}, 32'h1);
    busWrite(12'h024, 32'h1);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);
    busWrite(12'h034, 32'h0000_0001, 4'b0010);
    busRead(12'h020, 32'h0, "R8 set lane zero fill");

    // R10 fault capture
    pulseFault(32'h0000_1234, 32'h0000_ABCD);
    check("R10 irq on fault", {31'b0, irq}, 32'h1);
    busRead(12'h02C, 32'h0000_1234, "R10 fault addr");
    busRead(12'h030, 32'h0000_ABCD, "R10 fault info");
    pulseFault(32'h0000_9999, 32'h0000_7777);
    busRead(12'h02C, 32'h0000_1234, "R10 second fault ignored");
    busRead(12'h030, 32'h0000_ABCD, "R10 second info ignored");
    busWrite(12'h024, 32'h1);
    pulseFault(32'h0000_5555, 32'h0000_2222);
    busRead(12'h02C, 32'h0000_5555, "R10 recapture addr");
    busRead(12'h030, 32'h0000_2222, "R10 recapture info");
    busWrite(12'h024, 32'h1);

    // R7 non-secure shut out
    busRead(12'h000, 32'h0, "R7 ns read ctl", 4'hF, 1'b0);
    busWrite(12'h018, 32'd4, 4'hF, 1'b0);
    busRead(12'h018, 32'd2, "R7 ns ptr write dropped");
    busWrite(12'h000, 32'h8000_0000, 4'hF, 1'b0);
    busRead(12'h000, 32'h0000_0100, "R7 ns ctl write dropped");
    busWrite(12'h034, 32'h1, 4'hF, 1'b0);
    check("R7 ns set dropped", {31'b0, irq}, 32'h0);
    busRead(12'h01C, 32'h0, "R7 ns window read", 4'hF, 1'b0);
    busRead(12'h018, 32'd2, "R7 ns window no step");

    // R1 zero-reading offsets
    busRead(12'h024, 32'h0, "R1 clear reads zero");
    busRead(12'h034, 32'h0, "R1 set reads zero");
    busRead(12'h008, 32'h0, "R1 hole reads zero");
    busRead(12'h040, 32'h0, "R1 undecoded reads zero");

    // R6 lockdown
    busWrite(12'h018, 32'd0);
    busWrite(12'h000, 32'h8000_0100);
    busRead(12'h000, 32'h8000_0100, "R6 lock set");
    busWrite(12'h000, 32'h0);
    busRead(12'h000, 32'h8000_0100, "R6 ctl frozen");
    busWrite(12'h01C, 32'h0000_FFFF);
    busRead(12'h018, 32'd0, "R6 dropped window write no step");
    busRead(12'h01C, 32'h0000_00F0, "R6 window frozen");
    busRead(12'h018, 32'd1, "R6 read still steps");
    busWrite(12'h028, 32'h0);
    busRead(12'h028, 32'h1, "R6 enable frozen");
    busWrite(12'h018, 32'd3);
    busRead(12'h018, 32'd3, "R6 ptr writable");

    doReset();
    busRead(12'h000, 32'h0000_0100, "R6 reset clears lock");
    lookup(96, 1'b0, "R2 table cleared");

    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", 32'(expQ.size()), 32'h0);
    finishRun();
  end

endmodule